// File: doc/BRIEF.md
# SCSI Phase Control Register

This block is a byte-wide control and status register that sets the SCSI information-transfer phase. A microcontroller writes it and reads it back through a plain register port. When the chip runs as a target, three phase bits and a request bit drive the bus phase lines (I/O, C/D, MSG) and REQ. These lines are driven only while an external target-mode enable is set. All bus outputs are active-high assert signals. Conversion to the active-low open-collector bus levels happens outside the block.

When the chip runs as an initiator with DMA active, the same phase bits give the phase the initiator expects. The block synchronizes the observed bus phase and the active-low REQ line. On each new REQ assertion it compares the observed phase with the register. A difference sets a sticky mismatch interrupt, which software clears with a write-one strobe.

The register also holds a last-byte-sent status bit. The DMA side signals when it has handed over its final byte. The status bit sets only after that final byte has actually been transferred on the SCSI bus.

Top module: `phase_ctl_reg`

## Requirements
- R1: After reset, the read value is 0x00, every bus drive output is 0 and the mismatch interrupt is 0.
- R2: A write stores bits 3:0 (bit 0 = I/O, bit 1 = C/D, bit 2 = MSG, bit 3 = assert REQ). The read value returns them at the same positions. Bits 6:4 always read 0 and ignore write data.
- R3: While target mode is 1, the outputs bus_io_o, bus_cd_o, bus_msg_o and bus_req_o equal register bits 0, 1, 2 and 3. They follow a register or mode change one clock later.
- R4: While target mode is 0, all four drive outputs are 0 whatever the register holds. In particular the assert-REQ bit has no effect in initiator mode.
- R5: In initiator mode with dma_mode = 1, a new assertion of the active-low REQ input sets the interrupt if the observed phase {msg, cd, io} differs from register bits 2:0. The interrupt is set within SYNC_STAGES + 2 clocks of the REQ input falling.
- R6: A REQ assertion whose observed phase equals register bits 2:0 does not set the interrupt.
- R7: A REQ assertion sets no interrupt while dma_mode is 0 or target mode is 1.
- R8: The interrupt stays set until a one-cycle irq_clr_i strobe clears it. If a new mismatch arrives in the same cycle as the strobe, the interrupt stays set.
- R9: The interrupt responds to REQ edges, not levels. REQ held low after a clear does not set it again, and the next REQ assertion does.
- R10: Read bit 7 (last byte sent) sets on the first bus_byte_sent_i pulse that follows a dma_end_i pulse, and only in initiator mode. A byte sent in the same cycle as dma_end_i, or with no prior dma_end_i, does not set it.
- R11: Bit 7 clears on a dma_start_i pulse, which also discards a pending dma_end_i. It also clears on a register write with data bit 7 = 0. A write with bit 7 = 1 leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read value |
| target_mode_i | input | 1 | 1 = target role, bus drive enabled; 0 = initiator |
| dma_mode_i | input | 1 | DMA transfer mode active |
| irq_clr_i | input | 1 | Write-one-to-clear strobe for the interrupt |
| bus_req_n_i | input | 1 | Observed REQ, active low, asynchronous |
| bus_io_i | input | 1 | Observed I/O line (asserted = 1) |
| bus_cd_i | input | 1 | Observed C/D line (asserted = 1) |
| bus_msg_i | input | 1 | Observed MSG line (asserted = 1) |
| dma_start_i | input | 1 | New DMA transfer starts |
| dma_end_i | input | 1 | Last byte taken from the DMA side |
| bus_byte_sent_i | input | 1 | A byte completed its transfer on the SCSI bus |
| bus_io_o | output | 1 | Assert I/O |
| bus_cd_o | output | 1 | Assert C/D |
| bus_msg_o | output | 1 | Assert MSG |
| bus_req_o | output | 1 | Assert REQ |
| phase_irq_o | output | 1 | Sticky phase-mismatch interrupt |

## Verification
A vector table writes several register values under each role: all ones, data with reserved and status bits set, single-bit patterns and zero. This separates register storage and reserved-bit masking from output gating by target mode.

The mismatch logic is tried with four kinds of REQ assertion: one with a mismatched phase, one with a matching phase, one with DMA off and one in target role. This tells a correct compare from an always-on or gating-free one. Holding REQ low across a clear separates edge detection from level detection.

The last-byte flag is tried with four sequences: end and send in the same cycle, send without a prior end, end then send in target role, and the clears by write and by a new start.

// File: rtl/phase_ctl_pkg.sv
package phase_ctl_pkg;

    localparam int REG_W   = 8;
    localparam int PHASE_W = 3;

    // bit positions that software decodes
    localparam int BIT_IO   = 0;
    localparam int BIT_CD   = 1;
    localparam int BIT_MSG  = 2;
    localparam int BIT_REQ  = 3;
    localparam int BIT_LBS  = 7;

    // phase code as {msg, cd, io}
    typedef enum logic [PHASE_W-1:0] {
        PH_DATA_OUT = 3'b000,
        PH_DATA_IN  = 3'b001,
        PH_COMMAND  = 3'b010,
        PH_STATUS   = 3'b011,
        PH_RSVD_OUT = 3'b100,
        PH_RSVD_IN  = 3'b101,
        PH_MSG_OUT  = 3'b110,
        PH_MSG_IN   = 3'b111
    } phase_e;

    typedef struct packed {
        logic               areq;
        logic [PHASE_W-1:0] phase;
    } ctl_bits_t;

    typedef struct packed {
        logic req;
        logic msg;
        logic cd;
        logic io;
    } bus_drv_t;

endpackage

// File: rtl/phase_sync.sv
module phase_sync
    import phase_ctl_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_n_i,
    input  logic [PHASE_W-1:0] phase_i,
    output logic               req_fall_o,
    output logic [PHASE_W-1:0] phase_o
);

    localparam int LANE_W = PHASE_W + 1;
    localparam logic [LANE_W-1:0] LANE_RST = {1'b1, {PHASE_W{1'b0}}};

    typedef struct packed {
        logic [SYNC_STAGES-1:0][LANE_W-1:0] pipe;
        logic                               req_n_prev;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.pipe[0] = {req_n_i, phase_i};
        for (int i = 1; i < SYNC_STAGES; i++) begin
            st_d.pipe[i] = st_q.pipe[i-1];
        end
        st_d.req_n_prev = st_q.pipe[SYNC_STAGES-1][LANE_W-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.pipe       <= {SYNC_STAGES{LANE_RST}};
            st_q.req_n_prev <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign req_fall_o = st_q.req_n_prev & ~st_q.pipe[SYNC_STAGES-1][LANE_W-1];
    assign phase_o    = st_q.pipe[SYNC_STAGES-1][PHASE_W-1:0];

    // R9
    fall_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_fall_o |=> !req_fall_o);

endmodule

// File: rtl/mismatch_irq.sv
module mismatch_irq
    import phase_ctl_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               arm_i,
    input  logic               req_fall_i,
    input  logic [PHASE_W-1:0] obs_phase_i,
    input  logic [PHASE_W-1:0] exp_phase_i,
    input  logic               clr_i,
    output logic               irq_o
);

    typedef struct packed {
        logic irq;
    } irq_st_t;

    irq_st_t st_d, st_q;
    logic    hit;

    always_comb begin
        hit  = arm_i && req_fall_i && (obs_phase_i != exp_phase_i);
        st_d = st_q;
        if (clr_i) begin
            st_d.irq = 1'b0;
        end
        if (hit) begin
            st_d.irq = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_o = st_q.irq;

    // R5
    irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(arm_i && req_fall_i));

    // R8
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !clr_i) |=> irq_o);

endmodule

// File: rtl/lbs_track.sv
module lbs_track (
    input  logic clk,
    input  logic rst_n,
    input  logic initiator_i,
    input  logic dma_start_i,
    input  logic dma_end_i,
    input  logic byte_sent_i,
    input  logic wr_clr_i,
    output logic lbs_o
);

    typedef struct packed {
        logic pend;
        logic lbs;
    } lbs_st_t;

    lbs_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_clr_i) begin
            st_d.lbs = 1'b0;
        end
        if (st_q.pend && byte_sent_i && initiator_i) begin
            st_d.lbs  = 1'b1;
            st_d.pend = 1'b0;
        end
        if (dma_end_i) begin
            st_d.pend = 1'b1;
        end
        if (dma_start_i) begin
            st_d.lbs  = 1'b0;
            st_d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign lbs_o = st_q.lbs;

    // R10
    lbs_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lbs_o) |-> $past(byte_sent_i && initiator_i));

    // R11
    lbs_start_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dma_start_i |=> !lbs_o);

endmodule

// File: rtl/phase_ctl_reg.sv
module phase_ctl_reg
    import phase_ctl_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr_en_i,
    input  logic [REG_W-1:0] reg_wdata_i,
    output logic [REG_W-1:0] reg_rdata_o,
    input  logic             target_mode_i,
    input  logic             dma_mode_i,
    input  logic             irq_clr_i,
    input  logic             bus_req_n_i,
    input  logic             bus_io_i,
    input  logic             bus_cd_i,
    input  logic             bus_msg_i,
    input  logic             dma_start_i,
    input  logic             dma_end_i,
    input  logic             bus_byte_sent_i,
    output logic             bus_io_o,
    output logic             bus_cd_o,
    output logic             bus_msg_o,
    output logic             bus_req_o,
    output logic             phase_irq_o
);

    localparam int RSV_W = BIT_LBS - BIT_REQ - 1;

    typedef struct packed {
        ctl_bits_t ctl;
        bus_drv_t  drv;
    } top_st_t;

    top_st_t             st_d, st_q;
    logic                req_fall;
    logic [PHASE_W-1:0]  obs_phase;
    logic                lbs;
    logic                wr_lbs_clr;

    always_comb begin
        st_d = st_q;
        if (reg_wr_en_i) begin
            st_d.ctl.areq  = reg_wdata_i[BIT_REQ];
            st_d.ctl.phase = {reg_wdata_i[BIT_MSG], reg_wdata_i[BIT_CD], reg_wdata_i[BIT_IO]};
        end
        if (target_mode_i) begin
            st_d.drv.req = st_d.ctl.areq;
            st_d.drv.msg = st_d.ctl.phase[2];
            st_d.drv.cd  = st_d.ctl.phase[1];
            st_d.drv.io  = st_d.ctl.phase[0];
        end else begin
            st_d.drv = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_lbs_clr = reg_wr_en_i && !reg_wdata_i[BIT_LBS];

    phase_sync #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_n_i    (bus_req_n_i),
        .phase_i    ({bus_msg_i, bus_cd_i, bus_io_i}),
        .req_fall_o (req_fall),
        .phase_o    (obs_phase)
    );

    mismatch_irq u_irq (
        .clk         (clk),
        .rst_n       (rst_n),
        .arm_i       (!target_mode_i && dma_mode_i),
        .req_fall_i  (req_fall),
        .obs_phase_i (obs_phase),
        .exp_phase_i (st_q.ctl.phase),
        .clr_i       (irq_clr_i),
        .irq_o       (phase_irq_o)
    );

    lbs_track u_lbs (
        .clk         (clk),
        .rst_n       (rst_n),
        .initiator_i (!target_mode_i),
        .dma_start_i (dma_start_i),
        .dma_end_i   (dma_end_i),
        .byte_sent_i (bus_byte_sent_i),
        .wr_clr_i    (wr_lbs_clr),
        .lbs_o       (lbs)
    );

    assign reg_rdata_o = {lbs, {RSV_W{1'b0}}, st_q.ctl.areq, st_q.ctl.phase};
    assign bus_io_o    = st_q.drv.io;
    assign bus_cd_o    = st_q.drv.cd;
    assign bus_msg_o   = st_q.drv.msg;
    assign bus_req_o   = st_q.drv.req;

    // R4
    drive_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_o || bus_msg_o || bus_cd_o || bus_io_o) |-> $past(target_mode_i));

    // R3
    req_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (target_mode_i && !reg_wr_en_i) |=> (bus_req_o == reg_rdata_o[BIT_REQ]));

    // R11
    lbs_wr_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en_i && !reg_wdata_i[BIT_LBS] && !bus_byte_sent_i) |=> !reg_rdata_o[BIT_LBS]);

endmodule

// File: tb/sim_phase_ctl_reg.sv
`timescale 1ns/1ps
module sim_phase_ctl_reg;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       tm = 1'b0, dma = 1'b0, clr = 1'b0;
    logic       req_n = 1'b1, io_i = 1'b0, cd_i = 1'b0, msg_i = 1'b0;
    logic       start = 1'b0, dend = 1'b0, sent = 1'b0;
    logic       io_o, cd_o, msg_o, req_o, irq;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #10 clk = ~clk;

    phase_ctl_reg u0 (
        .clk(clk), .rst_n(rst_n),
        .reg_wr_en_i(wr_en), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
        .target_mode_i(tm), .dma_mode_i(dma), .irq_clr_i(clr),
        .bus_req_n_i(req_n), .bus_io_i(io_i), .bus_cd_i(cd_i), .bus_msg_i(msg_i),
        .dma_start_i(start), .dma_end_i(dend), .bus_byte_sent_i(sent),
        .bus_io_o(io_o), .bus_cd_o(cd_o), .bus_msg_o(msg_o), .bus_req_o(req_o),
        .phase_irq_o(irq)
    );

    // {target_mode, write data, expected {req,msg,cd,io}}
    localparam logic [12:0] VEC [0:6] = '{
        {1'b1, 8'h0F, 4'hF},
        {1'b1, 8'h75, 4'h5},
        {1'b0, 8'h0F, 4'h0},
        {1'b1, 8'h0A, 4'hA},
        {1'b0, 8'h03, 4'h0},
        {1'b1, 8'h00, 4'h0},
        {1'b1, 8'hF6, 4'h6}
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; wdata = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic pulse_clr();
        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0;
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [7:0] drv();
        return {4'h0, req_o, msg_o, cd_o, io_o};
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        wait_n(3);
        rst_n = 1'b1;
        wait_n(1);
        chk("R1 rdata", rdata, 8'h00);
        chk("R1 drive", drv(), 8'h00);
        chk("R1 irq", {7'h0, irq}, 8'h00);

        // R2 R3 R4 table walk
        for (int i = 0; i < 7; i++) begin
            @(negedge clk); tm = VEC[i][12]; wr_en = 1'b1; wdata = VEC[i][11:4];
            @(negedge clk); wr_en = 1'b0;
            chk("R2 readback", rdata, {4'h0, VEC[i][7:4]});
            chk(VEC[i][12] ? "R3 drive" : "R4 drive", drv(), {4'h0, VEC[i][3:0]});
        end

        // R4 target mode drop gates outputs, AREQ inert as initiator
        wr(8'h0F);
        chk("R3 drive all", drv(), 8'h0F);
        @(negedge clk); tm = 1'b0;
        @(negedge clk);
        chk("R4 drop", drv(), 8'h00);
        wr(8'h08);
        chk("R4 areq inert", drv(), 8'h00);

        // R5 mismatch: expect command 010, observe data in 001
        dma = 1'b1;
        wr(8'h02);
        {msg_i, cd_i, io_i} = 3'b001;
        @(negedge clk); req_n = 1'b0;
        wait_n(4);
        chk("R5 mismatch irq", {7'h0, irq}, 8'h01);
        chk("R5 rdata intact", rdata, 8'h02);

        // R8 sticky then cleared; R9 held REQ does not re-raise
        wait_n(3);
        chk("R8 sticky", {7'h0, irq}, 8'h01);
        pulse_clr();
        chk("R8 cleared", {7'h0, irq}, 8'h00);
        wait_n(5);
        chk("R9 level ignored", {7'h0, irq}, 8'h00);

        // R6 match gives no interrupt
        req_n = 1'b1; wait_n(4);
        {msg_i, cd_i, io_i} = 3'b010;
        @(negedge clk); req_n = 1'b0;
        wait_n(5);
        chk("R6 match no irq", {7'h0, irq}, 8'h00);

        // R7 dma off
        req_n = 1'b1; wait_n(4);
        {msg_i, cd_i, io_i} = 3'b111; dma = 1'b0;
        @(negedge clk); req_n = 1'b0;
        wait_n(5);
        chk("R7 dma off", {7'h0, irq}, 8'h00);

        // R7 target role
        req_n = 1'b1; wait_n(4);
        dma = 1'b1; tm = 1'b1;
        @(negedge clk); req_n = 1'b0;
        wait_n(5);
        chk("R7 target role", {7'h0, irq}, 8'h00);

        // R9 next edge re-raises
        req_n = 1'b1; tm = 1'b0; wait_n(4);
        @(negedge clk); req_n = 1'b0;
        wait_n(5);
        chk("R9 next edge", {7'h0, irq}, 8'h01);
        pulse_clr();
        req_n = 1'b1; dma = 1'b0;

        // R10 last byte sent
        wr(8'h00);
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0; dend = 1'b1; sent = 1'b1;
        @(negedge clk); dend = 1'b0; sent = 1'b0;
        chk("R10 same cycle", rdata, 8'h00);
        @(negedge clk); sent = 1'b1;
        @(negedge clk); sent = 1'b0;
        chk("R10 set after end", rdata, 8'h80);

        // R11 write bit7=1 keeps, bit7=0 clears
        wr(8'h80);
        chk("R11 write one keeps", rdata, 8'h80);
        wr(8'h01);
        chk("R11 write zero clears", rdata, 8'h01);

        // R11 start clears and drops pending end
        @(negedge clk); dend = 1'b1;
        @(negedge clk); dend = 1'b0; sent = 1'b1;
        @(negedge clk); sent = 1'b0;
        chk("R10 set again", rdata, 8'h81);
        @(negedge clk); dend = 1'b1;
        @(negedge clk); dend = 1'b0; start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk("R11 start clears", rdata, 8'h01);
        @(negedge clk); sent = 1'b1;
        @(negedge clk); sent = 1'b0;
        chk("R11 pending dropped", rdata, 8'h01);

        // R10 not in target role
        tm = 1'b1;
        @(negedge clk); dend = 1'b1;
        @(negedge clk); dend = 1'b0; sent = 1'b1;
        @(negedge clk); sent = 1'b0;
        chk("R10 target role", rdata, 8'h01);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule